// File: doc/BRIEF.md
# Trap Return State Update Unit

This unit carries out the two return-from-trap operations of a processor core: the supervisor-level return and the machine-level return. When the core retires a return, it presents the current privilege level, the virtualization flag, the interrupt-enable and previous-mode stack bits of the status register, the trap-control bits, the saved exception PCs and a few configuration flags. The unit decides in one step whether the return is legal. If it is, the unit produces the popped status stack, the privilege and virtualization mode to resume in, and the PC to jump to. If it is not, the unit produces an exception cause and leaves every state field as it was.

The legality checks follow a fixed priority, so the cause reported is always the highest-priority violation. The results are registered. A strobe captures one evaluation, and the outputs hold it until the next strobe, so the core's state registers can load the outputs on the `done_o` pulse.

Top module: `trapret_unit`

## Requirements
- R1: After reset `done_o` and `exc_o` are 0, `priv_o` is 3 (machine), `pc_o` is 0, and `virt_o` and every stack output are 0. Privilege encoding: 0 user, 1 supervisor, 3 machine.
- R2: A strobe on `ret_req` sampled at a clock edge makes `done_o` high for exactly the following cycle with that evaluation on the outputs. Without a strobe `done_o` and `exc_o` are 0 and every other output keeps its value, whatever the inputs do.
- R3: A supervisor return (`ret_is_m`=0) from user privilege reports an illegal instruction, cause 2. This check has the highest priority.
- R4: When `rvc_ok` is 0 and bits [1:0] of the selected return PC (`sepc_i` for a supervisor return, `mepc_i` for a machine return) are nonzero, a misaligned-fetch exception, cause 0, is reported. It ranks below the privilege check and above every other check.
- R5: A supervisor return with `st_tsr` set while below machine privilege reports cause 2. Otherwise, with `cur_virt` set and `hv_vtsr` set, it reports a virtual-instruction fault, cause 22.
- R6: A legal supervisor return sets SIE to the old SPIE, sets SPIE to 1 and SPP to 0, resumes at privilege {0,SPP} and returns `sepc_i`. MIE, MPIE, MPP and MPV pass through unchanged.
- R7: A legal supervisor return with `has_hyp`=1 and `cur_virt`=0 resumes with virtualization equal to the old SPV and clears SPV. Otherwise the virtualization flag and SPV are unchanged.
- R8: A machine return below machine privilege reports cause 2. A legal one sets MIE to the old MPIE, sets MPIE to 1, sets MPP to 0 if `umode_ok` is set and to 3 otherwise, clears MPV, resumes at the old MPP and returns `mepc_i`. SIE, SPIE, SPP and SPV pass through unchanged.
- R9: A legal machine return resumes with virtualization equal to the old MPV ANDed with (old MPP not equal to 3).
- R10: With `new_spec`=1, a legal supervisor return clears MPRV, and a legal machine return clears MPRV only when the old MPP is not 3. In every other case MPRV is unchanged.
- R11: On any exception `priv_o`, `virt_o` and all stack outputs equal their inputs, and `pc_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ret_req | input | 1 | Return strobe, one cycle |
| ret_is_m | input | 1 | 1 selects machine return, 0 supervisor return |
| cur_priv | input | 2 | Current privilege level |
| cur_virt | input | 1 | Current virtualization flag |
| st_sie | input | 1 | Supervisor interrupt enable |
| st_spie | input | 1 | Supervisor previous interrupt enable |
| st_spp | input | 1 | Supervisor previous privilege |
| st_mie | input | 1 | Machine interrupt enable |
| st_mpie | input | 1 | Machine previous interrupt enable |
| st_mpp | input | 2 | Machine previous privilege |
| st_mpv | input | 1 | Machine previous virtualization |
| st_mprv | input | 1 | Modify-privilege bit |
| st_tsr | input | 1 | Trap supervisor return |
| hv_vtsr | input | 1 | Trap supervisor return from a virtualized guest |
| hv_spv | input | 1 | Supervisor previous virtualization |
| has_hyp | input | 1 | Hypervisor support present |
| rvc_ok | input | 1 | 16-bit instructions supported |
| umode_ok | input | 1 | User mode implemented |
| new_spec | input | 1 | Newer privilege rules (MPRV clearing) |
| sepc_i | input | XLEN | Supervisor exception PC |
| mepc_i | input | XLEN | Machine exception PC |
| done_o | output | 1 | Result valid, one cycle |
| exc_o | output | 1 | Return raised an exception |
| cause_o | output | 5 | Exception cause, 0 when legal |
| priv_o | output | 2 | Privilege to resume in |
| virt_o | output | 1 | Virtualization to resume in |
| sie_o | output | 1 | New SIE |
| spie_o | output | 1 | New SPIE |
| spp_o | output | 1 | New SPP |
| mie_o | output | 1 | New MIE |
| mpie_o | output | 1 | New MPIE |
| mpp_o | output | 2 | New MPP |
| mpv_o | output | 1 | New MPV |
| mprv_o | output | 1 | New MPRV |
| spv_o | output | 1 | New SPV |
| pc_o | output | XLEN | Return target PC |

## Verification
An error in the check ordering shows as a wrong cause code on the `done_o` pulse of the first return whose inputs violate two rules at once. An error in the stack pop or the virtualization selection shows as a wrong field in that same cycle. A register that fails to hold corrupts the outputs in the idle cycle after the pulse, while the inputs are scrambled. The sweep covers every combination of privilege, return kind, stack bits, trap bits and alignment, so any such fault is seen within two cycles of the first vector that exposes it.

// File: rtl/trapret_pkg.sv
package trapret_pkg;

  localparam int CAUSE_W = 5;
  localparam int PRIV_W  = 2;

  localparam logic [PRIV_W-1:0] PRV_U = 2'd0;
  localparam logic [PRIV_W-1:0] PRV_S = 2'd1;
  localparam logic [PRIV_W-1:0] PRV_M = 2'd3;

  localparam logic [CAUSE_W-1:0] CAUSE_MISALIGN = 5'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL  = 5'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_VIRT     = 5'd22;

  // interrupt-enable / previous-mode stack
  typedef struct packed {
    logic              sie;
    logic              spie;
    logic              spp;
    logic              mie;
    logic              mpie;
    logic [PRIV_W-1:0] mpp;
    logic              mpv;
    logic              mprv;
    logic              spv;
  } stk_t;

  // outcome of one return evaluation
  typedef struct packed {
    logic               exc;
    logic [CAUSE_W-1:0] cause;
    logic [PRIV_W-1:0]  priv;
    logic               virt;
    stk_t               stk;
  } eval_t;

  function automatic logic pc_unaligned(input logic rvc, input logic [1:0] low);
    return !rvc && (low != 2'b00);
  endfunction

endpackage

// File: rtl/trapret_sret_eval.sv
module trapret_sret_eval
  import trapret_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [PRIV_W-1:0] cur_priv,
  input  logic              cur_virt,
  input  stk_t              cur_stk,
  input  logic              tsr,
  input  logic              vtsr,
  input  logic              has_hyp,
  input  logic              rvc_ok,
  input  logic              new_spec,
  input  logic [XLEN-1:0]   sepc,
  output eval_t             res,
  output logic [XLEN-1:0]   pc
);

  always_comb begin
    res.exc   = 1'b1;
    res.cause = CAUSE_ILLEGAL;
    res.priv  = cur_priv;
    res.virt  = cur_virt;
    res.stk   = cur_stk;
    pc        = '0;
    if (cur_priv == PRV_U) begin
      res.cause = CAUSE_ILLEGAL;
    end else if (pc_unaligned(rvc_ok, sepc[1:0])) begin
      res.cause = CAUSE_MISALIGN;
    end else if (tsr && (cur_priv != PRV_M)) begin
      res.cause = CAUSE_ILLEGAL;
    end else if (cur_virt && vtsr) begin
      res.cause = CAUSE_VIRT;
    end else begin
      res.exc      = 1'b0;
      res.cause    = '0;
      res.stk.sie  = cur_stk.spie;
      res.stk.spie = 1'b1;
      res.stk.spp  = 1'b0;
      res.priv     = {1'b0, cur_stk.spp};
      if (has_hyp && !cur_virt) begin
        res.virt    = cur_stk.spv;
        res.stk.spv = 1'b0;
      end
      if (new_spec) begin
        res.stk.mprv = 1'b0;
      end
      pc = sepc;
    end
  end

endmodule

// File: rtl/trapret_mret_eval.sv
module trapret_mret_eval
  import trapret_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [PRIV_W-1:0] cur_priv,
  input  logic              cur_virt,
  input  stk_t              cur_stk,
  input  logic              rvc_ok,
  input  logic              umode_ok,
  input  logic              new_spec,
  input  logic [XLEN-1:0]   mepc,
  output eval_t             res,
  output logic [XLEN-1:0]   pc
);

  logic leave_m;
  assign leave_m = (cur_stk.mpp != PRV_M);

  always_comb begin
    res.exc   = 1'b1;
    res.cause = CAUSE_ILLEGAL;
    res.priv  = cur_priv;
    res.virt  = cur_virt;
    res.stk   = cur_stk;
    pc        = '0;
    if (cur_priv != PRV_M) begin
      res.cause = CAUSE_ILLEGAL;
    end else if (pc_unaligned(rvc_ok, mepc[1:0])) begin
      res.cause = CAUSE_MISALIGN;
    end else begin
      res.exc      = 1'b0;
      res.cause    = '0;
      res.priv     = cur_stk.mpp;
      res.virt     = cur_stk.mpv && leave_m;
      res.stk.mie  = cur_stk.mpie;
      res.stk.mpie = 1'b1;
      res.stk.mpp  = umode_ok ? PRV_U : PRV_M;
      res.stk.mpv  = 1'b0;
      if (new_spec && leave_m) begin
        res.stk.mprv = 1'b0;
      end
      pc = mepc;
    end
  end

endmodule

// File: rtl/trapret_unit.sv
module trapret_unit
  import trapret_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ret_req,
  input  logic                ret_is_m,
  input  logic [1:0]          cur_priv,
  input  logic                cur_virt,
  input  logic                st_sie,
  input  logic                st_spie,
  input  logic                st_spp,
  input  logic                st_mie,
  input  logic                st_mpie,
  input  logic [1:0]          st_mpp,
  input  logic                st_mpv,
  input  logic                st_mprv,
  input  logic                st_tsr,
  input  logic                hv_vtsr,
  input  logic                hv_spv,
  input  logic                has_hyp,
  input  logic                rvc_ok,
  input  logic                umode_ok,
  input  logic                new_spec,
  input  logic [XLEN-1:0]     sepc_i,
  input  logic [XLEN-1:0]     mepc_i,
  output logic                done_o,
  output logic                exc_o,
  output logic [4:0]          cause_o,
  output logic [1:0]          priv_o,
  output logic                virt_o,
  output logic                sie_o,
  output logic                spie_o,
  output logic                spp_o,
  output logic                mie_o,
  output logic                mpie_o,
  output logic [1:0]          mpp_o,
  output logic                mpv_o,
  output logic                mprv_o,
  output logic                spv_o,
  output logic [XLEN-1:0]     pc_o
);

  stk_t            cur_stk;
  eval_t           s_res, m_res, pick;
  logic [XLEN-1:0] s_pc, m_pc, pick_pc;
  eval_t           res_q;
  logic [XLEN-1:0] pc_q;
  logic            done_q;

  assign cur_stk = '{sie: st_sie, spie: st_spie, spp: st_spp, mie: st_mie,
                     mpie: st_mpie, mpp: st_mpp, mpv: st_mpv, mprv: st_mprv,
                     spv: hv_spv};

  trapret_sret_eval #(.XLEN(XLEN)) u_sret (
    .cur_priv (cur_priv),
    .cur_virt (cur_virt),
    .cur_stk  (cur_stk),
    .tsr      (st_tsr),
    .vtsr     (hv_vtsr),
    .has_hyp  (has_hyp),
    .rvc_ok   (rvc_ok),
    .new_spec (new_spec),
    .sepc     (sepc_i),
    .res      (s_res),
    .pc       (s_pc)
  );

  trapret_mret_eval #(.XLEN(XLEN)) u_mret (
    .cur_priv (cur_priv),
    .cur_virt (cur_virt),
    .cur_stk  (cur_stk),
    .rvc_ok   (rvc_ok),
    .umode_ok (umode_ok),
    .new_spec (new_spec),
    .mepc     (mepc_i),
    .res      (m_res),
    .pc       (m_pc)
  );

  assign pick    = ret_is_m ? m_res : s_res;
  assign pick_pc = ret_is_m ? m_pc  : s_pc;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q     <= 1'b0;
      res_q      <= '0;
      res_q.priv <= PRV_M;
      pc_q       <= '0;
    end else begin
      done_q <= ret_req;
      if (ret_req) begin
        res_q <= pick;
        pc_q  <= pick_pc;
      end else begin
        res_q.exc <= 1'b0;
      end
    end
  end

  assign done_o  = done_q;
  assign exc_o   = res_q.exc;
  assign cause_o = res_q.cause;
  assign priv_o  = res_q.priv;
  assign virt_o  = res_q.virt;
  assign sie_o   = res_q.stk.sie;
  assign spie_o  = res_q.stk.spie;
  assign spp_o   = res_q.stk.spp;
  assign mie_o   = res_q.stk.mie;
  assign mpie_o  = res_q.stk.mpie;
  assign mpp_o   = res_q.stk.mpp;
  assign mpv_o   = res_q.stk.mpv;
  assign mprv_o  = res_q.stk.mprv;
  assign spv_o   = res_q.stk.spv;
  assign pc_o    = pc_q;

endmodule

// File: rtl/trapret_unit_chk.sv
module trapret_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            ret_req,
  input logic            ret_is_m,
  input logic [1:0]      cur_priv,
  input logic [1:0]      st_mpp,
  input logic            new_spec,
  input logic            done_o,
  input logic            exc_o,
  input logic [4:0]      cause_o,
  input logic [1:0]      priv_o,
  input logic            spie_o,
  input logic            spp_o,
  input logic            mpie_o,
  input logic            mpv_o,
  input logic            mprv_o,
  input logic [XLEN-1:0] pc_o
);

  p_done_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (done_o == $past(ret_req)));

  p_hold_when_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ret_req)) |-> ($stable(pc_o) && $stable(priv_o) && !exc_o));

  p_exc_only_with_done_r2: assert property (@(posedge clk) disable iff (rst)
    exc_o |-> done_o);

  p_user_sret_illegal_r3: assert property (@(posedge clk) disable iff (rst)
    (done_o && !$past(ret_is_m) && ($past(cur_priv) == 2'd0)) |-> (exc_o && cause_o == 5'd2));

  p_mret_needs_machine_r8: assert property (@(posedge clk) disable iff (rst)
    (done_o && $past(ret_is_m) && ($past(cur_priv) != 2'd3)) |-> (exc_o && cause_o == 5'd2));

  p_sret_pop_r6: assert property (@(posedge clk) disable iff (rst)
    (done_o && !exc_o && !$past(ret_is_m)) |-> (spie_o && !spp_o));

  p_mret_pop_r8: assert property (@(posedge clk) disable iff (rst)
    (done_o && !exc_o && $past(ret_is_m)) |-> (mpie_o && !mpv_o && priv_o == $past(st_mpp)));

  p_mprv_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (done_o && !exc_o && $past(new_spec) && (!$past(ret_is_m) || $past(st_mpp) != 2'd3)) |-> !mprv_o);

  p_exc_zero_pc_r11: assert property (@(posedge clk) disable iff (rst)
    exc_o |-> (pc_o == '0));

endmodule

bind trapret_unit trapret_unit_chk #(.XLEN(XLEN)) i_chk (.*);

// File: tb/test_trapret_unit.sv
`timescale 1ns/100ps
module test_trapret_unit;

  localparam int XLEN = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic ret_req = 0, ret_is_m = 0, cur_virt = 0;
  logic [1:0] cur_priv = 0, st_mpp = 0;
  logic st_sie = 0, st_spie = 0, st_spp = 0, st_mie = 0, st_mpie = 0, st_mpv = 0;
  logic st_mprv = 0, st_tsr = 0, hv_vtsr = 0, hv_spv = 0;
  logic has_hyp = 0, rvc_ok = 0, umode_ok = 0, new_spec = 0;
  logic [XLEN-1:0] sepc_i = 0, mepc_i = 0;

  logic done_o, exc_o, virt_o, sie_o, spie_o, spp_o, mie_o, mpie_o, mpv_o, mprv_o, spv_o;
  logic [4:0] cause_o;
  logic [1:0] priv_o, mpp_o;
  logic [XLEN-1:0] pc_o;

  trapret_unit #(.XLEN(XLEN)) i_trapret_unit (.*);

  int checks = 0;
  int errors = 0;

  localparam int BW = 19 + XLEN;
  logic [BW-1:0] act, expv, prev;
  assign act = {exc_o, cause_o, priv_o, virt_o, sie_o, spie_o, spp_o, mie_o, mpie_o,
                mpp_o, mpv_o, mprv_o, spv_o, pc_o};

  task automatic check(input string req, input logic [BW-1:0] a, input logic [BW-1:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, a, e);
    end
  endtask

  // independent model of the return rules
  task automatic model(output logic [BW-1:0] e, output string tag);
    logic x; logic [4:0] c; logic [1:0] p; logic v;
    logic sie, spie, spp, mie, mpie, mpv, mprv, spv; logic [1:0] mpp;
    logic [XLEN-1:0] pc;
    x = 0; c = 0; p = cur_priv; v = cur_virt;
    sie = st_sie; spie = st_spie; spp = st_spp; mie = st_mie; mpie = st_mpie;
    mpp = st_mpp; mpv = st_mpv; mprv = st_mprv; spv = hv_spv; pc = 0;
    if (!ret_is_m) begin
      tag = "R6 R7 R10";
      if (cur_priv == 2'd0) begin x = 1; c = 2; tag = "R3 R11"; end
      else if (!rvc_ok && sepc_i[1:0] != 0) begin x = 1; c = 0; tag = "R4 R11"; end
      else if (st_tsr && cur_priv != 2'd3) begin x = 1; c = 2; tag = "R5 R11"; end
      else if (cur_virt && hv_vtsr) begin x = 1; c = 22; tag = "R5 R11"; end
      else begin
        sie = st_spie; spie = 1; spp = 0; p = {1'b0, st_spp}; pc = sepc_i;
        if (has_hyp && !cur_virt) begin v = hv_spv; spv = 0; end
        if (new_spec) mprv = 0;
      end
    end else begin
      tag = "R8 R9 R10";
      if (cur_priv != 2'd3) begin x = 1; c = 2; tag = "R8 R11"; end
      else if (!rvc_ok && mepc_i[1:0] != 0) begin x = 1; c = 0; tag = "R4 R11"; end
      else begin
        mie = st_mpie; mpie = 1; mpp = umode_ok ? 2'd0 : 2'd3; mpv = 0;
        p = st_mpp; v = st_mpv && (st_mpp != 2'd3); pc = mepc_i;
        if (new_spec && st_mpp != 2'd3) mprv = 0;
      end
    end
    e = {x, c, p, v, sie, spie, spp, mie, mpie, mpp, mpv, mprv, spv, pc};
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    string tag;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    check("R1", {done_o, act}, {1'b0, 1'b0, 5'd0, 2'd3, 1'b0, 10'd0, {XLEN{1'b0}}});
    for (int i = 0; i < 65536; i++) begin
      logic [15:0] v;
      v = i[15:0];
      ret_is_m = v[0];  cur_priv = v[2:1]; cur_virt = v[3];
      st_spp = v[4];    st_spie = v[5];    st_mpie = v[6];
      st_mpp = v[8:7];  st_mpv = v[9];     st_tsr = v[10];
      hv_vtsr = v[11];  hv_spv = v[12];    rvc_ok = v[13];
      umode_ok = v[15];
      st_sie = v[0] ^ v[5] ^ v[9];
      st_mie = v[1] ^ v[6] ^ v[11];
      st_mprv = ~(v[3] ^ v[9]);
      new_spec = v[1] ^ v[7] ^ v[12];
      has_hyp = v[2] ^ v[10] ^ v[14];
      sepc_i = {v, 14'h1A5C, v[14], 1'b0};
      mepc_i = {~v, 14'h2B3D, v[14], 1'b0};
      model(expv, tag);
      ret_req = 1;
      @(negedge clk);
      // R2: result lands one cycle after the strobe
      checks++;
      if (done_o !== 1'b1) begin
        errors++;
        $display("FAIL R2 done actual=%b expected=1", done_o);
      end
      check(tag, act, expv);
      prev = act;
      // idle cycle with scrambled inputs
      ret_req = 0;
      cur_priv = ~cur_priv; ret_is_m = ~ret_is_m; st_spie = ~st_spie;
      st_mpp = ~st_mpp; sepc_i = ~sepc_i; mepc_i = ~mepc_i; rvc_ok = 1;
      @(negedge clk);
      // R2: outputs hold, done and exc low
      check("R2 hold", {done_o, act}, {1'b0, 1'b0, prev[BW-2:0]});
    end
    finish_run();
  end

endmodule